// File: doc/BRIEF.md
# Fieldbus Service Handshake and Statistics Controller

This block is the register window through which a host processor steers an I/O bus engine. The host writes a service request byte. The block runs the bus re-initialisation that the request asks for and reports completion, or failure, through a response byte. The exchange is four-phase: the host sets the request, the block sets the response, the host drops the request, and the block drops the response. Only after that can the same service run again.

Alongside the handshake the block keeps bus statistics. It counts completed I/O cycles and retried cycles. It measures the time of the last cycle in microseconds, using a clock prescaler. It holds a bus status byte that is zero when the bus is healthy, and it latches the error code and argument that a failed re-initialisation leaves behind. It also stores two host-relocatable base pointers, one for the input process image and one for the output process image. The bus engine is represented by ports: a cycle request, a cycle done, a cycle error, and the outcome of a re-initialisation.

The service sequencer has four states: SV_IDLE (waiting for a request), SV_WIPE (one cycle that clears the statistics and fault bytes), SV_INIT (bus re-initialisation in progress, `bus_init_o` high), and SV_DONE (response posted, waiting for the host to drop its request). The transitions are:
- IDLE→WIPE on request bit 0.
- WIPE→INIT unconditionally.
- INIT→DONE on the engine's done pulse.
- DONE→IDLE once request bit 0 reads zero. The response is cleared on this transition.

Top module: `fbs_ctrl`

## Requirements
- R1: Request register (address 0x0) bit 1 is stored and reads back, but it has no effect: no re-initialisation starts, and the response register (address 0x1) bit 1 stays 0. Request bits 7..2 always read as 0.
- R2: Setting request bit 0 while idle raises `bus_init_o` within two clocks. It stays high until `bus_init_done_i` is sampled high. A clean outcome then sets the response register to 0x01.
- R3: While request bit 0 stays set, the response stays set and `bus_init_o` stays low. The response reads 0x00 on the second clock after the host writes bit 0 to zero. A later request runs a new re-initialisation.
- R4: After a clean re-initialisation, the error code (0x4), the error argument (0x5) and the bus status (0x2) all read 0x00, and `pd_error_o` is 0.
- R5: After a failed re-initialisation (`bus_init_ok_i` low at the done pulse), the response reads 0x81. The error code and argument hold the values of `bus_fault_code_i` and `bus_fault_arg_i`, the status reads 0x01, and `pd_error_o` is 1.
- R6: The 16-bit cycle counter (low byte 0x6, high byte 0x7) increments once for every clock in which `cyc_done_i` is high.
- R7: The cycle time (low byte 0x8, high byte 0x9) is captured when `cyc_done_i` is sampled k clocks after `cyc_req_i`. The captured value is floor((k-1)/US_DIV) microseconds, and it saturates at 0xFFFF.
- R8: The 8-bit retry counter (0x3) increments for every clock in which `cyc_err_i` is high, and wraps from 0xFF to 0x00.
- R9: A re-initialisation clears the cycle counter, the retry counter, the error bytes and the status. It leaves the cycle time and the base pointers unchanged.
- R10: The input base pointer (0xA low, 0xB high) resets to 0x0000 and the output base pointer (0xC low, 0xD high) resets to 0x0200. Each byte is host-writable and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | AW | Register byte address |
| host_wr | input | 1 | Write strobe for host_wdata |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| cyc_req_i | input | 1 | Host starts an I/O cycle |
| cyc_done_i | input | 1 | Engine reports cycle complete |
| cyc_err_i | input | 1 | Engine repeated a cycle after a communication error |
| bus_init_o | output | 1 | Re-initialisation in progress |
| bus_init_done_i | input | 1 | Engine finished re-initialisation |
| bus_init_ok_i | input | 1 | Outcome of re-initialisation, valid with done |
| bus_fault_code_i | input | 8 | Fault code reported by engine |
| bus_fault_arg_i | input | 8 | Fault argument reported by engine |
| pd_error_o | output | 1 | Process-data error flag, high when status is non-zero |

## Verification
The bench holds the request set long after the response appears. A design that did not wait for the request to drop would restart the bus or clear the response early. The bench runs a failed re-initialisation followed by a clean one; a design that forgot to wipe the fault bytes would still report the old code and a raised error flag. The cycle-time test covers short and odd intervals as well as a run past 0xFFFF microseconds, which catches off-by-one prescaler counting and a wrapping timer. Driving more than 256 retry pulses confirms that the retry counter wraps, and setting request bit 1 confirms that the reserved service changes nothing.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [1:0] {
        SV_IDLE = 2'd0,
        SV_WIPE = 2'd1,
        SV_INIT = 2'd2,
        SV_DONE = 2'd3
    } sv_state_t;

    localparam int CNT_W = 16;
    localparam int RTY_W = 8;

    localparam int A_REQ   = 0;
    localparam int A_RSP   = 1;
    localparam int A_STAT  = 2;
    localparam int A_RETRY = 3;
    localparam int A_ECODE = 4;
    localparam int A_EARG  = 5;
    localparam int A_CCNTL = 6;
    localparam int A_CCNTH = 7;
    localparam int A_CTIML = 8;
    localparam int A_CTIMH = 9;
    localparam int A_INBL  = 10;
    localparam int A_INBH  = 11;
    localparam int A_OUTBL = 12;
    localparam int A_OUTBH = 13;

    localparam logic [7:0]  STAT_FAULT   = 8'h01;
    localparam logic [15:0] IN_BASE_RST  = 16'h0000;
    localparam logic [15:0] OUT_BASE_RST = 16'h0200;
endpackage

// File: rtl/fbs_service.sv
module fbs_service
    import fbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_rst_i,
    input  logic       init_done_i,
    input  logic       init_ok_i,
    input  logic [7:0] fault_code_i,
    input  logic [7:0] fault_arg_i,
    output logic       bus_init_o,
    output logic       wipe_o,
    output logic [7:0] rsp_o,
    output logic [7:0] err_code_o,
    output logic [7:0] err_arg_o,
    output logic [7:0] status_o
);
    sv_state_t state_q, state_d;
    logic rsp_done, rsp_err;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_IDLE: if (req_rst_i)   state_d = SV_WIPE;
            SV_WIPE:                  state_d = SV_INIT;
            SV_INIT: if (init_done_i) state_d = SV_DONE;
            SV_DONE: if (!req_rst_i)  state_d = SV_IDLE;
            default:                  state_d = SV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done   <= 1'b0;
            rsp_err    <= 1'b0;
            err_code_o <= '0;
            err_arg_o  <= '0;
            status_o   <= '0;
        end else begin
            unique case (state_q)
                SV_WIPE: begin
                    err_code_o <= '0;
                    err_arg_o  <= '0;
                    status_o   <= '0;
                end
                SV_INIT: if (init_done_i) begin
                    rsp_done   <= 1'b1;
                    rsp_err    <= !init_ok_i;
                    err_code_o <= init_ok_i ? 8'h00 : fault_code_i;
                    err_arg_o  <= init_ok_i ? 8'h00 : fault_arg_i;
                    status_o   <= init_ok_i ? 8'h00 : STAT_FAULT;
                end
                SV_DONE: if (!req_rst_i) begin
                    rsp_done <= 1'b0;
                    rsp_err  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign bus_init_o = (state_q == SV_INIT);
    assign wipe_o     = (state_q == SV_WIPE);
    assign rsp_o      = {rsp_err, 6'b0, rsp_done};

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && req_rst_i) |=> rsp_done); // R3
    AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsp_done) |-> !$past(req_rst_i)); // R3
    AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_err) |-> (err_code_o == 8'h00 && err_arg_o == 8'h00 && status_o == 8'h00)); // R4
    AST_ERR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_done) |-> (rsp_err == (status_o != 8'h00))); // R5
endmodule

// File: rtl/fbs_ustick.sv
module fbs_ustick #(
    parameter int US_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (US_DIV > 1) ? $clog2(US_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(US_DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) pre_q <= '0;
        else if (tick_o)         pre_q <= '0;
        else                     pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/fbs_stats.sv
module fbs_stats
    import fbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             done_i,
    input  logic             err_i,
    output logic [CNT_W-1:0] cyc_cnt_o,
    output logic [CNT_W-1:0] cyc_time_o,
    output logic [RTY_W-1:0] retry_o
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] live_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q     <= '0;
            run_q      <= 1'b0;
            cyc_time_o <= '0;
        end else begin
            if (done_i && run_q) cyc_time_o <= live_q;
            if (start_i) begin
                live_q <= '0;
                run_q  <= 1'b1;
            end else begin
                if (done_i) run_q <= 1'b0;
                if (run_q && tick_i && live_q != SAT) live_q <= live_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cyc_cnt_o <= '0;
            retry_o   <= '0;
        end else begin
            if (done_i) cyc_cnt_o <= cyc_cnt_o + 1'b1;
            if (err_i)  retry_o   <= retry_o + 1'b1;
        end
    end

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !clr_i) |=> (cyc_cnt_o == $past(cyc_cnt_o) + 1'b1)); // R6
    AST_RETRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !clr_i) |=> (retry_o == $past(retry_o) + 1'b1)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && live_q == SAT && !start_i) |=> (live_q == SAT)); // R7
    AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cyc_cnt_o == '0 && retry_o == '0)); // R9
endmodule

// File: rtl/fbs_ctrl.sv
module fbs_ctrl
    import fbs_pkg::*;
#(
    parameter int AW     = 4,
    parameter int US_DIV = 125
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          cyc_req_i,
    input  logic          cyc_done_i,
    input  logic          cyc_err_i,
    output logic          bus_init_o,
    input  logic          bus_init_done_i,
    input  logic          bus_init_ok_i,
    input  logic [7:0]    bus_fault_code_i,
    input  logic [7:0]    bus_fault_arg_i,
    output logic          pd_error_o
);
    logic [1:0]       req_q;
    logic [15:0]      in_base_q, out_base_q;
    logic [7:0]       rsp, err_code, err_arg, status;
    logic             wipe, tick;
    logic [CNT_W-1:0] cyc_cnt, cyc_time;
    logic [RTY_W-1:0] retry;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q      <= '0;
            in_base_q  <= IN_BASE_RST;
            out_base_q <= OUT_BASE_RST;
        end else if (host_wr) begin
            if (host_addr == AW'(A_REQ))   req_q            <= host_wdata[1:0];
            if (host_addr == AW'(A_INBL))  in_base_q[7:0]   <= host_wdata;
            if (host_addr == AW'(A_INBH))  in_base_q[15:8]  <= host_wdata;
            if (host_addr == AW'(A_OUTBL)) out_base_q[7:0]  <= host_wdata;
            if (host_addr == AW'(A_OUTBH)) out_base_q[15:8] <= host_wdata;
        end
    end

    fbs_service u_service (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_rst_i    (req_q[0]),
        .init_done_i  (bus_init_done_i),
        .init_ok_i    (bus_init_ok_i),
        .fault_code_i (bus_fault_code_i),
        .fault_arg_i  (bus_fault_arg_i),
        .bus_init_o   (bus_init_o),
        .wipe_o       (wipe),
        .rsp_o        (rsp),
        .err_code_o   (err_code),
        .err_arg_o    (err_arg),
        .status_o     (status)
    );

    fbs_ustick #(.US_DIV(US_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (cyc_req_i),
        .tick_o    (tick)
    );

    fbs_stats u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (wipe),
        .tick_i     (tick),
        .start_i    (cyc_req_i),
        .done_i     (cyc_done_i),
        .err_i      (cyc_err_i),
        .cyc_cnt_o  (cyc_cnt),
        .cyc_time_o (cyc_time),
        .retry_o    (retry)
    );

    assign pd_error_o = (status != 8'h00);

    always_comb begin
        unique case (int'(host_addr))
            A_REQ:   host_rdata = {6'b0, req_q};
            A_RSP:   host_rdata = rsp;
            A_STAT:  host_rdata = status;
            A_RETRY: host_rdata = retry;
            A_ECODE: host_rdata = err_code;
            A_EARG:  host_rdata = err_arg;
            A_CCNTL: host_rdata = cyc_cnt[7:0];
            A_CCNTH: host_rdata = cyc_cnt[15:8];
            A_CTIML: host_rdata = cyc_time[7:0];
            A_CTIMH: host_rdata = cyc_time[15:8];
            A_INBL:  host_rdata = in_base_q[7:0];
            A_INBH:  host_rdata = in_base_q[15:8];
            A_OUTBL: host_rdata = out_base_q[7:0];
            A_OUTBH: host_rdata = out_base_q[15:8];
            default: host_rdata = 8'h00;
        endcase
    end

    AST_FREE_RUN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_q[0] && !bus_init_o) |=> !bus_init_o); // R1
    AST_INIT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_init_o) |-> req_q[0] || $past(req_q[0])); // R2
endmodule

// File: tb/fbs_ctrl_tb_top.sv
`timescale 1ns/1ps
module fbs_ctrl_tb_top;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       cyc_req = 1'b0, cyc_done = 1'b0, cyc_err = 1'b0;
    logic       bus_init;
    logic       init_done = 1'b0, init_ok = 1'b0;
    logic [7:0] fcode = '0, farg = '0;
    logic       pd_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fbs_ctrl #(.AW(4), .US_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cyc_req_i(cyc_req),
        .cyc_done_i(cyc_done), .cyc_err_i(cyc_err), .bus_init_o(bus_init),
        .bus_init_done_i(init_done), .bus_init_ok_i(init_ok),
        .bus_fault_code_i(fcode), .bus_fault_arg_i(farg), .pd_error_o(pd_err)
    );

    typedef struct {
        logic [3:0] a;
        logic [7:0] v;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    bit   mon_busy = 1'b0;

    initial begin : monitor
        exp_t it;
        forever begin
            wait (sb_q.size() > 0);
            mon_busy = 1'b1;
            it = sb_q.pop_front();
            @(negedge clk);
            host_addr = it.a;
            #1;
            checks++;
            if (host_rdata !== it.v) begin
                errors++;
                $display("FAIL %s addr 0x%h actual 0x%h expected 0x%h", it.tag, it.a, host_rdata, it.v);
            end
            mon_busy = 1'b0;
        end
    end

    task automatic expect_reg(input logic [3:0] a, input logic [7:0] v, input string tag);
        exp_t it;
        it.a = a; it.v = v; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        wait (!mon_busy);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // request at edge P0, done sampled at edge Pk
    task automatic run_cycle(input int k);
        @(negedge clk); cyc_req = 1'b1;
        @(negedge clk); cyc_req = 1'b0;
        repeat (k - 1) @(negedge clk);
        cyc_done = 1'b1;
        @(negedge clk); cyc_done = 1'b0;
    endtask

    task automatic bus_reset(input logic ok, input logic [7:0] c, input logic [7:0] g);
        int n;
        wr(4'h0, 8'h01);
        n = 0;
        while (!bus_init && n < 10) begin @(negedge clk); n++; end
        check_bit("R2 bus_init raised", bus_init, 1'b1);
        init_done = 1'b1; init_ok = ok; fcode = c; farg = g;
        @(negedge clk);
        init_done = 1'b0; fcode = 8'h00; farg = 8'h00;
    endtask

    task automatic release_req();
        wr(4'h0, 8'h00);
        @(negedge clk);
        expect_reg(4'h1, 8'h00, "R3 response cleared after request drop");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        int exp_ccnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        expect_reg(4'h0, 8'h00, "R1 request after reset");
        expect_reg(4'h1, 8'h00, "R3 response after reset");
        expect_reg(4'h2, 8'h00, "R4 status after reset");
        expect_reg(4'hA, 8'h00, "R10 in base lo reset");
        expect_reg(4'hB, 8'h00, "R10 in base hi reset");
        expect_reg(4'hC, 8'h00, "R10 out base lo reset");
        expect_reg(4'hD, 8'h02, "R10 out base hi reset");
        check_bit("R5 pd_error after reset", pd_err, 1'b0);

        // base pointers
        wr(4'hA, 8'h34); wr(4'hB, 8'h01); wr(4'hC, 8'h80); wr(4'hD, 8'h03);
        expect_reg(4'hA, 8'h34, "R10 in base lo write");
        expect_reg(4'hB, 8'h01, "R10 in base hi write");
        expect_reg(4'hC, 8'h80, "R10 out base lo write");
        expect_reg(4'hD, 8'h03, "R10 out base hi write");

        // cycles and timing
        run_cycle(21);
        expect_reg(4'h8, 8'd10, "R7 cycle time k=21");
        run_cycle(2);
        expect_reg(4'h8, 8'd0, "R7 cycle time k=2");
        run_cycle(8);
        expect_reg(4'h8, 8'd3, "R7 cycle time k=8");
        expect_reg(4'h9, 8'd0, "R7 cycle time hi");
        exp_ccnt = 3;
        expect_reg(4'h6, 8'(exp_ccnt), "R6 cycle count after three");
        expect_reg(4'h7, 8'h00, "R6 cycle count hi");

        // retries
        @(negedge clk); cyc_err = 1'b1;
        repeat (5) @(negedge clk);
        cyc_err = 1'b0;
        expect_reg(4'h3, 8'd5, "R8 retry count five");

        // free run request has no effect
        wr(4'h0, 8'h02);
        repeat (6) begin
            @(negedge clk);
            check_bit("R1 free run starts nothing", bus_init, 1'b0);
        end
        expect_reg(4'h0, 8'h02, "R1 request bit1 reads back");
        expect_reg(4'h1, 8'h00, "R1 response bit1 stays low");
        wr(4'h0, 8'hFC);
        expect_reg(4'h0, 8'h00, "R1 upper request bits read zero");

        // clean re-initialisation
        bus_reset(1'b1, 8'h55, 8'h66);
        expect_reg(4'h1, 8'h01, "R2 clean response");
        expect_reg(4'h4, 8'h00, "R4 error code clean");
        expect_reg(4'h5, 8'h00, "R4 error arg clean");
        expect_reg(4'h2, 8'h00, "R4 status clean");
        expect_reg(4'h6, 8'h00, "R9 cycle count wiped");
        expect_reg(4'h3, 8'h00, "R9 retry wiped");
        expect_reg(4'h8, 8'd3, "R9 cycle time kept");
        expect_reg(4'hB, 8'h01, "R9 in base kept");
        expect_reg(4'hD, 8'h03, "R9 out base kept");
        repeat (8) begin
            @(negedge clk);
            check_bit("R3 no rerun while request held", bus_init, 1'b0);
        end
        expect_reg(4'h1, 8'h01, "R3 response held");
        release_req();

        // failed re-initialisation
        run_cycle(4);
        bus_reset(1'b0, 8'h12, 8'h07);
        expect_reg(4'h1, 8'h81, "R5 error response");
        expect_reg(4'h4, 8'h12, "R5 error code");
        expect_reg(4'h5, 8'h07, "R5 error arg");
        expect_reg(4'h2, 8'h01, "R5 status fault");
        expect_reg(4'h6, 8'h00, "R9 cycle count wiped again");
        check_bit("R5 pd_error raised", pd_err, 1'b1);
        release_req();
        check_bit("R5 pd_error holds after release", pd_err, 1'b1);

        // second clean run clears fault
        bus_reset(1'b1, 8'h00, 8'h00);
        expect_reg(4'h1, 8'h01, "R3 new request reruns");
        expect_reg(4'h4, 8'h00, "R4 error code cleared");
        expect_reg(4'h2, 8'h00, "R4 status cleared");
        check_bit("R4 pd_error cleared", pd_err, 1'b0);
        release_req();

        // retry wrap
        @(negedge clk); cyc_err = 1'b1;
        repeat (260) @(negedge clk);
        cyc_err = 1'b0;
        expect_reg(4'h3, 8'd4, "R8 retry wraps");

        // cycle time saturation
        run_cycle(131200);
        expect_reg(4'h8, 8'hFF, "R7 saturated lo");
        expect_reg(4'h9, 8'hFF, "R7 saturated hi");
        expect_reg(4'h6, 8'd1, "R6 cycle count after wipe");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule